// File: doc/BRIEF.md
# Stochastic Hard-Sigmoid Binarizer

This block turns one signed fixed-point sample into a single binary code per accepted input, where a code bit of 1 stands for +1 and 0 stands for -1. In stochastic mode the chance of a 1 follows a clipped linear map of the input. That chance is p = (x + 1) / 2, held between 0 and 1. The block draws its random number from an internal 16-bit Galois LFSR and compares it with p. In deterministic mode the code is simply the sign of the input, with zero counted as positive.

The input side has no handshake. A sample is taken in every cycle in which `in_valid_i` is high, and its code appears one clock later together with `out_valid_o`. The generator can be reseeded through a separate load strobe at any time. The load may fall in the same cycle as a sample.

Top module: `sh_binarizer`

## Requirements
- R1: After reset, `out_valid_o` and `out_bit_o` are 0 and the generator state is 16'hACE1.
- R2: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high, and low otherwise.
- R3: With `stoch_mode_i` = 0, the code is 1 when the Q2.8 input (10 bits, two's complement, 256 = 1.0) is zero or positive, and 0 when it is negative.
- R4: With `stoch_mode_i` = 1 and -256 < x < 256, the code is 1 exactly when r < floor((x + 256) / 2). Here r is bits [15:8] of the generator state, read as unsigned.
- R5: With `stoch_mode_i` = 1 and x <= -256, the code is always 0.
- R6: With `stoch_mode_i` = 1 and x >= 256, the code is always 1.
- R7: The generator shifts right and XORs 16'hB400 into the state when the bit shifted out is 1. It advances once per accepted sample in either mode, and each sample uses the state from before its own advance.
- R8: In a cycle with neither `in_valid_i` nor `seed_load_i`, the generator state does not change.
- R9: `seed_load_i` loads `seed_i` into the generator. An all-zero seed is replaced by 16'hACE1.
- R10: When `seed_load_i` and `in_valid_i` are both high, the sample uses the loaded seed (after any zero replacement). The state then becomes that seed advanced by one step.
- R11: `out_bit_o` keeps its last value in cycles that follow a cycle without `in_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample present this cycle |
| in_value_i | input | 10 | Signed Q2.8 sample |
| stoch_mode_i | input | 1 | 1 = stochastic, 0 = sign |
| seed_load_i | input | 1 | Load generator seed |
| seed_i | input | 16 | Seed value |
| out_valid_o | output | 1 | Code valid |
| out_bit_o | output | 1 | Code: 1 = +1, 0 = -1 |

## Verification
A seed load and an accepted sample can happen in the same cycle. The bench provokes this by raising both strobes together with a chosen seed and a zero input. The seed is picked so that its upper byte sits on either side of the probability 128, which forces a known code. The samples that follow are then compared against a reference generator. That reference has stepped once from the loaded seed, so a wrong priority or a missed advance shows up as a mismatch.

// File: rtl/sh_bin_pkg.sv
package sh_bin_pkg;
  localparam int unsigned LFSR_W_DEF = 16;
  localparam logic [LFSR_W_DEF-1:0] TAPS_DEF = 16'hB400;
  localparam logic [LFSR_W_DEF-1:0] SEED_ALT_DEF = 16'hACE1;

  typedef enum logic {
    MODE_SIGN  = 1'b0,
    MODE_STOCH = 1'b1
  } bin_mode_e;
endpackage

// File: rtl/sh_bin_lfsr.sv
module sh_bin_lfsr #(
  parameter int unsigned LFSR_W = 16,
  parameter int unsigned RND_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_ALT = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [RND_W-1:0]  rnd_o
);
  logic [LFSR_W-1:0] state_q, cur, stepped, seed_ok;

  assign seed_ok = (seed_i == '0) ? SEED_ALT : seed_i;
  // a load in the same cycle supplies the number used by that sample
  assign cur     = load_i ? seed_ok : state_q;
  assign stepped = cur[0] ? ((cur >> 1) ^ TAPS) : (cur >> 1);
  assign rnd_o   = cur[LFSR_W-1 -: RND_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              state_q <= SEED_ALT;
    else if (adv_i)           state_q <= stepped;
    else if (load_i)          state_q <= seed_ok;
  end
endmodule

// File: rtl/sh_bin_prob.sv
module sh_bin_prob #(
  parameter int unsigned IN_W = 10,
  parameter int unsigned FRAC_W = 8
) (
  input  logic [IN_W-1:0]   x_i,
  output logic [FRAC_W:0]   p2_o,   // twice the probability, 1/2^(FRAC_W+1) units
  output logic              low_o,
  output logic              full_o
);
  localparam int ONE = 1 << FRAC_W;
  logic signed [IN_W:0] sum;

  assign sum    = $signed({x_i[IN_W-1], x_i}) + $signed((IN_W+1)'(ONE));
  assign low_o  = sum <= $signed((IN_W+1)'(0));
  assign full_o = sum >= $signed((IN_W+1)'(2 * ONE));
  assign p2_o   = sum[FRAC_W:0];
endmodule

// File: rtl/sh_binarizer.sv
module sh_binarizer
  import sh_bin_pkg::*;
#(
  parameter int unsigned IN_W = 10,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned LFSR_W = LFSR_W_DEF,
  parameter logic [LFSR_W-1:0] TAPS = TAPS_DEF,
  parameter logic [LFSR_W-1:0] SEED_ALT = SEED_ALT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [IN_W-1:0]   in_value_i,
  input  logic              stoch_mode_i,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic              out_valid_o,
  output logic              out_bit_o
);
  localparam int unsigned RND_W = FRAC_W;

  logic [RND_W-1:0] rnd;
  logic [FRAC_W:0]  p2;
  logic             low, full, stoch_bit, code;
  bin_mode_e        mode;
  logic             valid_q, bit_q;

  sh_bin_lfsr #(
    .LFSR_W(LFSR_W), .RND_W(RND_W), .TAPS(TAPS), .SEED_ALT(SEED_ALT)
  ) u_lfsr (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(in_valid_i),
    .load_i(seed_load_i), .seed_i(seed_i), .rnd_o(rnd)
  );

  sh_bin_prob #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_prob (
    .x_i(in_value_i), .p2_o(p2), .low_o(low), .full_o(full)
  );

  assign mode = bin_mode_e'(stoch_mode_i);
  // {r,1} < 2p+e equals r < floor(p) without dropping the input LSB
  assign stoch_bit = full | (~low & ({rnd, 1'b1} < p2));

  always_comb begin
    unique case (mode)
      MODE_STOCH: code = stoch_bit;
      default:    code = ~in_value_i[IN_W-1];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) bit_q <= code;
    end
  end

  assign out_valid_o = valid_q;
  assign out_bit_o   = bit_q;
endmodule

// File: rtl/sh_binarizer_chk.sv
module sh_binarizer_chk #(
  parameter int unsigned IN_W = 10,
  parameter int unsigned FRAC_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic [IN_W-1:0] in_value_i,
  input logic            stoch_mode_i,
  input logic            out_valid_o,
  input logic            out_bit_o
);
  localparam int ONE = 1 << FRAC_W;

  // R2
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  // R3
  sign_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !stoch_mode_i) |=> (out_bit_o == !$past(in_value_i[IN_W-1])));
  // R5
  sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && stoch_mode_i && ($signed(in_value_i) <= -ONE)) |=> !out_bit_o);
  // R6
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && stoch_mode_i && ($signed(in_value_i) >= ONE)) |=> out_bit_o);
  // R11
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_bit_o));
endmodule

bind sh_binarizer sh_binarizer_chk #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .in_value_i(in_value_i), .stoch_mode_i(stoch_mode_i),
  .out_valid_o(out_valid_o), .out_bit_o(out_bit_o)
);

// File: tb/sh_binarizer_test.sv
`timescale 1ns/1ps
module sh_binarizer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [9:0]  in_value_i = '0;
  logic        stoch_mode_i = 1'b0;
  logic        seed_load_i = 1'b0;
  logic [15:0] seed_i = '0;
  logic        out_valid_o, out_bit_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] ms = 16'hACE1;  // reference generator
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  sh_binarizer uut (.*);

  function automatic logic [15:0] nx(logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  function automatic bit expect_stoch(int x, logic [15:0] s);
    int r = int'(s[15:8]);
    if (x >= 256) return 1'b1;
    if (x <= -256) return 1'b0;
    return r < ((x + 256) / 2);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle stimulus, result sampled on the following falling edge
  task automatic step(int x, bit mode, bit vld, bit ld, logic [15:0] sd, string req);
    bit e;
    @(negedge clk_i);
    in_valid_i = vld; in_value_i = 10'(x); stoch_mode_i = mode;
    seed_load_i = ld; seed_i = sd;
    if (ld) ms = (sd == 16'h0) ? 16'hACE1 : sd;
    e = mode ? expect_stoch(x, ms) : (x >= 0);
    if (vld) ms = nx(ms);
    @(negedge clk_i);
    in_valid_i = 1'b0; seed_load_i = 1'b0;
    chk(out_valid_o == vld, {req, " valid"}, int'(out_valid_o), int'(vld));
    if (vld) chk(out_bit_o == e, req, int'(out_bit_o), int'(e));
  endtask

  task automatic t_reset;
    chk(out_valid_o == 1'b0, "R1 valid", int'(out_valid_o), 0);
    chk(out_bit_o == 1'b0, "R1 bit", int'(out_bit_o), 0);
  endtask

  task automatic t_stoch;
    int xs[10] = '{0, 100, -100, 255, -255, 128, -1, 1, 64, -200};
    foreach (xs[i]) step(xs[i], 1'b1, 1'b1, 1'b0, 16'h0, "R4 R7 R1");
    for (int i = 0; i < 40; i++) step((i * 13) % 511 - 255, 1'b1, 1'b1, 1'b0, 16'h0, "R4 R7");
  endtask

  task automatic t_sign;
    int xs[6] = '{-1, 0, 5, -512, 511, -256};
    foreach (xs[i]) step(xs[i], 1'b0, 1'b1, 1'b0, 16'h0, "R3 R2");
    step(40, 1'b1, 1'b1, 1'b0, 16'h0, "R7 sign-mode advance");
  endtask

  task automatic t_sat;
    for (int i = 0; i < 6; i++) begin
      step(-256 - i * 50, 1'b1, 1'b1, 1'b0, 16'h0, "R5");
      step(256 + i * 50, 1'b1, 1'b1, 1'b0, 16'h0, "R6");
    end
  endtask

  task automatic t_idle;
    bit last;
    step(30, 1'b1, 1'b1, 1'b0, 16'h0, "R4");
    last = out_bit_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(out_valid_o == 1'b0, "R2 idle", int'(out_valid_o), 0);
      chk(out_bit_o == last, "R11 hold", int'(out_bit_o), int'(last));
    end
    step(0, 1'b1, 1'b1, 1'b0, 16'h0, "R8 state held");
    step(-60, 1'b1, 1'b1, 1'b0, 16'h0, "R8 state held");
  endtask

  task automatic t_seed;
    step(0, 1'b1, 1'b0, 1'b1, 16'h1234, "R9 load only");
    for (int i = 0; i < 6; i++) step(i * 40 - 100, 1'b1, 1'b1, 1'b0, 16'h0, "R9 after load");
    step(0, 1'b1, 1'b0, 1'b1, 16'h0000, "R9 zero seed");
    for (int i = 0; i < 6; i++) step(i * 40 - 100, 1'b1, 1'b1, 1'b0, 16'h0, "R9 zero replaced");
  endtask

  task automatic t_both;
    step(0, 1'b1, 1'b1, 1'b1, 16'h8F00, "R10 load+sample low");
    for (int i = 0; i < 4; i++) step(i * 30, 1'b1, 1'b1, 1'b0, 16'h0, "R10 successor");
    step(0, 1'b1, 1'b1, 1'b1, 16'h0100, "R10 load+sample high");
    for (int i = 0; i < 4; i++) step(-i * 30, 1'b1, 1'b1, 1'b0, 16'h0, "R10 successor");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_stoch;
    t_sign;
    t_sat;
    t_idle;
    t_seed;
    t_both;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule